// File: doc/BRIEF.md
# Interrupt Distributor Pending-State Store

This block keeps the per-interrupt state of a multi-CPU interrupt distributor. Every interrupt owns a bitmask with one bit per CPU for each of five attributes (enable, latched pending, active, sampled input level, group). It also owns two scalar bits: a trigger-mode bit (edge or level) and a one-of-N bit that marks an interrupt as handled by any single CPU. Each interrupt also has an 8-bit priority. The priority is banked per CPU for the low internal interrupt IDs and held once for every other ID.

Software changes the state through a single-cycle command port. Each command carries an opcode, an interrupt ID, a CPU mask, a CPU number and a priority byte. The input lines are sampled every clock, one bit per interrupt and CPU. A rising edge on an edge-triggered interrupt latches pending. The query port is combinational. It reports the effective pending status of any interrupt under any CPU mask, and for level-triggered interrupts that status includes the live level term. A second combinational port returns the priority for an interrupt and CPU. A legacy-revision input drops the level term from the pending status.

Top module: `irq_pend_state`

## Requirements
- R1: After reset every enable, pending, active, group, level, trigger-mode and one-of-N bit is 0 (level-triggered, not one-of-N), every priority reads 0, and all query outputs are 0.
- R2: A command with `cmd_valid` high takes effect on the next clock edge. Its opcode on `cmd_op` selects the action:
  - 1/2 set/clear enable bits under `cmd_mask`;
  - 5/6 set/clear active bits;
  - 7/8 set/clear group bits;
  - 9/10 set/clear edge-triggered mode;
  - 11/12 set/clear one-of-N mode;
  - codes 0, 14 and 15 change nothing.
- R3: For a level-triggered interrupt, `q_pending` is 1 when any latched pending bit under `q_mask` is set, or when any input line under `q_mask` was high at the previous clock edge. Line bit `i*NCPU+c` belongs to interrupt `i`, CPU `c`.
- R4: For an edge-triggered interrupt, a 0-to-1 change of a line between two consecutive clock samples latches that CPU's pending bit. A line held high does not latch again after a clear. The line level alone never makes an edge-triggered interrupt pending.
- R5: A level-triggered interrupt whose line is still high keeps reporting pending after its latched bit is cleared.
- R6: Opcode 3 sets pending bits under `cmd_mask`. Opcode 4 clears the pending bits under `cmd_mask`, or every CPU's pending bit when the interrupt is in one-of-N mode.
- R7: When a rising edge on an edge-triggered interrupt arrives in the same cycle as a clear-pending command for that CPU, the bit ends up set.
- R8: While `legacy_rev` is 1, `q_pending` reflects only latched pending bits, with no level term.
- R9: Opcode 13 writes `cmd_prio` as the priority. For IDs below `NINTERNAL` each CPU, selected by `cmd_cpu`, has its own copy, and a write to one copy leaves the others and the shared priorities unchanged.
- R10: For IDs from `NINTERNAL` upward one priority is shared by all CPUs. `p_prio` returns it whatever `p_cpu` is.
- R11: The query outputs are combinational from `q_irq`, `q_mask` and the stored state. `q_enabled`, `q_active` and `q_group` are 1 when any bit under `q_mask` is set. `q_edge` and `q_model` give the two mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_rev | input | 1 | Drop the level term from pending status |
| lvl_in | input | NIRQ*NCPU | Interrupt input lines, bit i*NCPU+c |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_irq | input | clog2(NIRQ) | Command interrupt ID |
| cmd_mask | input | NCPU | Command CPU mask |
| cmd_cpu | input | clog2(NCPU) | CPU for priority writes |
| cmd_prio | input | 8 | Priority value to write |
| q_irq | input | clog2(NIRQ) | Query interrupt ID |
| q_mask | input | NCPU | Query CPU mask |
| q_pending | output | 1 | Effective pending under mask |
| q_enabled | output | 1 | Any enable bit under mask |
| q_active | output | 1 | Any active bit under mask |
| q_group | output | 1 | Any group bit under mask |
| q_edge | output | 1 | Interrupt is edge-triggered |
| q_model | output | 1 | Interrupt is one-of-N |
| p_irq | input | clog2(NIRQ) | Priority lookup interrupt ID |
| p_cpu | input | clog2(NCPU) | Priority lookup CPU |
| p_prio | output | 8 | Priority for that interrupt and CPU |

## Verification
The assertions assume that the input lines are synchronous to `clk` and that a command is a single-cycle strobe whose ID lies below `NIRQ`. They also assume that one command at most arrives per cycle. Under those assumptions a new pending bit always traces back to a set command or a sampled edge, and a clear touches exactly the bits it names. The stimulus changes lines, commands and queries only on the falling clock edge. It restricts random IDs to valid interrupts near both ends and near the banked boundary, so the edge-versus-clear and one-of-N cases recur often.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
package irq_pend_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_EN_SET    = 4'd1,
    OP_EN_CLR    = 4'd2,
    OP_PEND_SET  = 4'd3,
    OP_PEND_CLR  = 4'd4,
    OP_ACT_SET   = 4'd5,
    OP_ACT_CLR   = 4'd6,
    OP_GRP_SET   = 4'd7,
    OP_GRP_CLR   = 4'd8,
    OP_EDGE_SET  = 4'd9,
    OP_EDGE_CLR  = 4'd10,
    OP_MODEL_SET = 4'd11,
    OP_MODEL_CLR = 4'd12,
    OP_PRIO_WR   = 4'd13
  } ips_op_e;
endpackage

// File: rtl/irq_line_sampler.sv
`timescale 1ns/1ps
module irq_line_sampler #(
  parameter int NBITS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] lvl_in,
  output logic [NBITS-1:0] lvl_o,
  output logic [NBITS-1:0] rise_o
);
  logic [NBITS-1:0] lvl_q;
  logic [NBITS-1:0] lvl_d;

  always_comb begin
    lvl_d = lvl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_in & ~lvl_q;
endmodule

// File: rtl/irq_attr_slice.sv
`timescale 1ns/1ps
module irq_attr_slice
  import irq_pend_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  ips_op_e         op,
  input  logic [NCPU-1:0] mask,
  input  logic [NCPU-1:0] rise,
  output logic [NCPU-1:0] en_o,
  output logic [NCPU-1:0] pend_o,
  output logic [NCPU-1:0] act_o,
  output logic [NCPU-1:0] grp_o,
  output logic            edge_o,
  output logic            model_o
);
  logic [NCPU-1:0] en_q, pend_q, act_q, grp_q;
  logic [NCPU-1:0] en_d, pend_d, act_d, grp_d;
  logic            edge_q, model_q, edge_d, model_d;
  logic            attr_upd, pend_upd, edge_hit;

  assign edge_hit = edge_q & (|rise);

  always_comb begin
    en_d    = en_q;
    pend_d  = pend_q;
    act_d   = act_q;
    grp_d   = grp_q;
    edge_d  = edge_q;
    model_d = model_q;
    if (sel) begin
      case (op)
        OP_EN_SET:    en_d    = en_q | mask;
        OP_EN_CLR:    en_d    = en_q & ~mask;
        OP_PEND_SET:  pend_d  = pend_q | mask;
        OP_PEND_CLR:  pend_d  = pend_q & ~(model_q ? {NCPU{1'b1}} : mask);
        OP_ACT_SET:   act_d   = act_q | mask;
        OP_ACT_CLR:   act_d   = act_q & ~mask;
        OP_GRP_SET:   grp_d   = grp_q | mask;
        OP_GRP_CLR:   grp_d   = grp_q & ~mask;
        OP_EDGE_SET:  edge_d  = 1'b1;
        OP_EDGE_CLR:  edge_d  = 1'b0;
        OP_MODEL_SET: model_d = 1'b1;
        OP_MODEL_CLR: model_d = 1'b0;
        default: ;
      endcase
    end
    if (edge_q) pend_d = pend_d | rise;
  end

  assign attr_upd = sel;
  assign pend_upd = sel | edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      grp_q   <= '0;
      edge_q  <= 1'b0;
      model_q <= 1'b0;
    end else begin
      if (attr_upd) begin
        en_q    <= en_d;
        act_q   <= act_d;
        grp_q   <= grp_d;
        edge_q  <= edge_d;
        model_q <= model_d;
      end
      if (pend_upd) pend_q <= pend_d;
    end
  end

  assign en_o    = en_q;
  assign pend_o  = pend_q;
  assign act_o   = act_q;
  assign grp_o   = grp_q;
  assign edge_o  = edge_q;
  assign model_o = model_q;

  // R4
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> ((pend_q & $past(rise)) == $past(rise)));

  // R6
  model_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_PEND_CLR && model_q && !edge_hit) |=> (pend_q == '0));

  // R6
  own_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_PEND_CLR && !model_q && !edge_hit) |=>
      ((((pend_q ^ $past(pend_q)) & ~$past(mask)) == '0) && ((pend_q & $past(mask)) == '0)));

  // R4
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) != '0) |->
      ($past(sel && op == OP_PEND_SET) || $past(edge_hit)));
endmodule

// File: rtl/irq_prio_store.sv
`timescale 1ns/1ps
module irq_prio_store #(
  parameter int NIRQ      = 64,
  parameter int NCPU      = 4,
  parameter int NINTERNAL = 32,
  parameter int PW        = 8,
  parameter int IW        = 6,
  parameter int CW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_irq,
  input  logic [CW-1:0] wr_cpu,
  input  logic [PW-1:0] wr_data,
  input  logic [IW-1:0] rd_irq,
  input  logic [CW-1:0] rd_cpu,
  output logic [PW-1:0] rd_prio
);
  localparam int NSH = NIRQ - NINTERNAL;

  logic [NINTERNAL-1:0][NCPU-1:0][PW-1:0] bank_q, bank_d;
  logic [NSH-1:0][PW-1:0]                 sh_q, sh_d;
  logic                                   upd;

  assign upd = wr_en;

  always_comb begin
    bank_d = bank_q;
    sh_d   = sh_q;
    for (int j = 0; j < NINTERNAL; j++) begin
      for (int c = 0; c < NCPU; c++) begin
        if (wr_en && int'(wr_irq) == j && int'(wr_cpu) == c) bank_d[j][c] = wr_data;
      end
    end
    for (int j = 0; j < NSH; j++) begin
      if (wr_en && int'(wr_irq) == j + NINTERNAL) sh_d[j] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      sh_q   <= '0;
    end else if (upd) begin
      bank_q <= bank_d;
      sh_q   <= sh_d;
    end
  end

  always_comb begin
    rd_prio = '0;
    for (int j = 0; j < NINTERNAL; j++) begin
      for (int c = 0; c < NCPU; c++) begin
        if (int'(rd_irq) == j && int'(rd_cpu) == c) rd_prio = bank_q[j][c];
      end
    end
    for (int j = 0; j < NSH; j++) begin
      if (int'(rd_irq) == j + NINTERNAL) rd_prio = sh_q[j];
    end
  end

  // R9
  shared_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_irq) < NINTERNAL) |=> $stable(sh_q));

  // R10
  bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_irq) >= NINTERNAL) |=> $stable(bank_q));
endmodule

// File: rtl/irq_pend_state.sv
`timescale 1ns/1ps
module irq_pend_state
  import irq_pend_pkg::*;
#(
  parameter int NCPU      = 4,
  parameter int NIRQ      = 64,
  parameter int NINTERNAL = 32,
  parameter int PW        = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  legacy_rev,
  input  logic [NIRQ*NCPU-1:0]                  lvl_in,
  input  logic                                  cmd_valid,
  input  logic [3:0]                            cmd_op,
  input  logic [$clog2(NIRQ)-1:0]               cmd_irq,
  input  logic [NCPU-1:0]                       cmd_mask,
  input  logic [(NCPU > 1 ? $clog2(NCPU) : 1)-1:0] cmd_cpu,
  input  logic [PW-1:0]                         cmd_prio,
  input  logic [$clog2(NIRQ)-1:0]               q_irq,
  input  logic [NCPU-1:0]                       q_mask,
  output logic                                  q_pending,
  output logic                                  q_enabled,
  output logic                                  q_active,
  output logic                                  q_group,
  output logic                                  q_edge,
  output logic                                  q_model,
  input  logic [$clog2(NIRQ)-1:0]               p_irq,
  input  logic [(NCPU > 1 ? $clog2(NCPU) : 1)-1:0] p_cpu,
  output logic [PW-1:0]                         p_prio
);
  localparam int IW    = $clog2(NIRQ);
  localparam int CW    = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int NBITS = NIRQ * NCPU;

  ips_op_e op_e;
  assign op_e = ips_op_e'(cmd_op);

  logic [NBITS-1:0] lvl_flat, rise_flat;
  logic [NIRQ-1:0][NCPU-1:0] lvl_a, rise_a, en_a, pend_a, act_a, grp_a;
  logic [NIRQ-1:0] edge_a, model_a;

  irq_line_sampler #(.NBITS(NBITS)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (lvl_in),
    .lvl_o  (lvl_flat),
    .rise_o (rise_flat)
  );

  assign lvl_a  = lvl_flat;
  assign rise_a = rise_flat;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    logic sel_i;
    assign sel_i = cmd_valid && (cmd_irq == IW'(i));
    irq_attr_slice #(.NCPU(NCPU)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_i),
      .op      (op_e),
      .mask    (cmd_mask),
      .rise    (rise_a[i]),
      .en_o    (en_a[i]),
      .pend_o  (pend_a[i]),
      .act_o   (act_a[i]),
      .grp_o   (grp_a[i]),
      .edge_o  (edge_a[i]),
      .model_o (model_a[i])
    );
  end

  irq_prio_store #(
    .NIRQ(NIRQ), .NCPU(NCPU), .NINTERNAL(NINTERNAL), .PW(PW), .IW(IW), .CW(CW)
  ) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_valid && op_e == OP_PRIO_WR),
    .wr_irq  (cmd_irq),
    .wr_cpu  (cmd_cpu),
    .wr_data (cmd_prio),
    .rd_irq  (p_irq),
    .rd_cpu  (p_cpu),
    .rd_prio (p_prio)
  );

  logic lat_hit, lvl_hit;

  always_comb begin
    lat_hit   = 1'b0;
    lvl_hit   = 1'b0;
    q_enabled = 1'b0;
    q_active  = 1'b0;
    q_group   = 1'b0;
    q_edge    = 1'b0;
    q_model   = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      if (int'(q_irq) == i) begin
        lat_hit   = |(pend_a[i] & q_mask);
        lvl_hit   = |(lvl_a[i] & q_mask);
        q_enabled = |(en_a[i] & q_mask);
        q_active  = |(act_a[i] & q_mask);
        q_group   = |(grp_a[i] & q_mask);
        q_edge    = edge_a[i];
        q_model   = model_a[i];
      end
    end
    q_pending = lat_hit | (~legacy_rev & ~q_edge & lvl_hit);
  end
endmodule

// File: tb/tb_irq_pend_state.sv
`timescale 1ns/1ps
module tb_irq_pend_state;
  localparam int NCPU = 4;
  localparam int NIRQ = 64;
  localparam int NINT = 32;
  localparam int PW   = 8;
  localparam int IW   = 6;
  localparam int CW   = 2;

  localparam logic [3:0] C_EN_SET = 1, C_EN_CLR = 2, C_P_SET = 3, C_P_CLR = 4,
    C_A_SET = 5, C_A_CLR = 6, C_G_SET = 7, C_G_CLR = 8, C_E_SET = 9, C_E_CLR = 10,
    C_M_SET = 11, C_M_CLR = 12, C_PRIO = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy_rev = 1'b0;
  logic [NIRQ*NCPU-1:0] lvl_in = '0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [IW-1:0] cmd_irq = '0;
  logic [NCPU-1:0] cmd_mask = '0;
  logic [CW-1:0] cmd_cpu = '0;
  logic [PW-1:0] cmd_prio = '0;
  logic [IW-1:0] q_irq = '0;
  logic [NCPU-1:0] q_mask = '0;
  logic [IW-1:0] p_irq = '0;
  logic [CW-1:0] p_cpu = '0;
  logic q_pending, q_enabled, q_active, q_group, q_edge, q_model;
  logic [PW-1:0] p_prio;

  always #2.5 clk = ~clk;

  irq_pend_state #(.NCPU(NCPU), .NIRQ(NIRQ), .NINTERNAL(NINT), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .legacy_rev(legacy_rev), .lvl_in(lvl_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_irq(cmd_irq), .cmd_mask(cmd_mask),
    .cmd_cpu(cmd_cpu), .cmd_prio(cmd_prio), .q_irq(q_irq), .q_mask(q_mask),
    .q_pending(q_pending), .q_enabled(q_enabled), .q_active(q_active),
    .q_group(q_group), .q_edge(q_edge), .q_model(q_model),
    .p_irq(p_irq), .p_cpu(p_cpu), .p_prio(p_prio)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_chk = 0;
  bit done = 0;

  // Reference model
  logic [NCPU-1:0] m_en[NIRQ], m_pend[NIRQ], m_act[NIRQ], m_grp[NIRQ], m_lvl[NIRQ];
  bit m_edge[NIRQ], m_model[NIRQ];
  logic [PW-1:0] m_pb[NINT][NCPU];
  logic [PW-1:0] m_ps[NIRQ];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIRQ; i++) begin
        m_en[i] = '0; m_pend[i] = '0; m_act[i] = '0; m_grp[i] = '0; m_lvl[i] = '0;
        m_edge[i] = 0; m_model[i] = 0; m_ps[i] = '0;
      end
      for (int i = 0; i < NINT; i++)
        for (int c = 0; c < NCPU; c++) m_pb[i][c] = '0;
    end else begin
      bit old_edge[NIRQ];
      for (int i = 0; i < NIRQ; i++) old_edge[i] = m_edge[i];
      if (cmd_valid) begin
        int k;
        k = int'(cmd_irq);
        case (cmd_op)
          C_EN_SET: m_en[k] |= cmd_mask;
          C_EN_CLR: m_en[k] &= ~cmd_mask;
          C_P_SET:  m_pend[k] |= cmd_mask;
          C_P_CLR:  m_pend[k] &= (m_model[k] ? 4'b0000 : ~cmd_mask);
          C_A_SET:  m_act[k] |= cmd_mask;
          C_A_CLR:  m_act[k] &= ~cmd_mask;
          C_G_SET:  m_grp[k] |= cmd_mask;
          C_G_CLR:  m_grp[k] &= ~cmd_mask;
          C_E_SET:  m_edge[k] = 1;
          C_E_CLR:  m_edge[k] = 0;
          C_M_SET:  m_model[k] = 1;
          C_M_CLR:  m_model[k] = 0;
          C_PRIO: begin
            if (k < NINT) m_pb[k][cmd_cpu] = cmd_prio;
            else          m_ps[k] = cmd_prio;
          end
          default: ;
        endcase
      end
      for (int i = 0; i < NIRQ; i++) begin
        logic [NCPU-1:0] now;
        now = lvl_in[i*NCPU +: NCPU];
        if (old_edge[i]) m_pend[i] |= (now & ~m_lvl[i]);
        m_lvl[i] = now;
      end
    end
  end

  function automatic bit mq_pend(int i, logic [NCPU-1:0] m);
    return (|(m_pend[i] & m)) || (!legacy_rev && !m_edge[i] && (|(m_lvl[i] & m)));
  endfunction

  function automatic logic [PW-1:0] mq_prio(int i, int c);
    return (i < NINT) ? m_pb[i][c] : m_ps[i];
  endfunction

  // Per-clock comparison of every query output against the model (R11)
  always @(negedge clk) begin
    #2;
    if (run_chk && !done) begin
      int qi, pi;
      logic [5:0] exp_v, act_v;
      qi = int'(q_irq);
      pi = int'(p_irq);
      exp_v = {mq_pend(qi, q_mask), |(m_en[qi] & q_mask), |(m_act[qi] & q_mask),
               |(m_grp[qi] & q_mask), m_edge[qi], m_model[qi]};
      act_v = {q_pending, q_enabled, q_active, q_group, q_edge, q_model};
      n_chk++;
      if (exp_v !== act_v || p_prio !== mq_prio(pi, int'(p_cpu))) begin
        n_fail++;
        $display("FAIL R11 model compare irq=%0d mask=%b: actual %b prio %h, expected %b prio %h",
                 qi, q_mask, act_v, p_prio, exp_v, mq_prio(pi, int'(p_cpu)));
      end
    end
  end

  task automatic cmd(input logic [3:0] op, input int irq, input logic [NCPU-1:0] m,
                     input int cpu = 0, input int pr = 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_irq = IW'(irq); cmd_mask = m;
    cmd_cpu = CW'(cpu); cmd_prio = PW'(pr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_line(input int irq, input int cpu, input logic v);
    @(negedge clk);
    lvl_in[irq*NCPU + cpu] = v;
    @(negedge clk);
  endtask

  task automatic chk(input int irq, input logic [NCPU-1:0] m, input logic exp, input string tag);
    @(negedge clk);
    q_irq = IW'(irq); q_mask = m;
    #0.5;
    n_chk++;
    if (q_pending !== exp) begin
      n_fail++;
      $display("FAIL %s pending irq=%0d mask=%b: actual %b expected %b", tag, irq, m, q_pending, exp);
    end
  endtask

  task automatic chkattr(input int irq, input logic [NCPU-1:0] m, input logic [4:0] exp,
                         input string tag);
    @(negedge clk);
    q_irq = IW'(irq); q_mask = m;
    #0.5;
    n_chk++;
    if ({q_enabled, q_active, q_group, q_edge, q_model} !== exp) begin
      n_fail++;
      $display("FAIL %s attrs irq=%0d mask=%b: actual %b expected %b", tag, irq, m,
               {q_enabled, q_active, q_group, q_edge, q_model}, exp);
    end
  endtask

  task automatic chkp(input int irq, input int cpu, input logic [PW-1:0] exp, input string tag);
    @(negedge clk);
    p_irq = IW'(irq); p_cpu = CW'(cpu);
    #0.5;
    n_chk++;
    if (p_prio !== exp) begin
      n_fail++;
      $display("FAIL %s prio irq=%0d cpu=%0d: actual %h expected %h", tag, irq, cpu, p_prio, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1;

    // R1 reset state
    chk(0, 4'hF, 1'b0, "R1");
    chkattr(63, 4'hF, 5'b00000, "R1");
    chkp(0, 0, 8'h00, "R1");
    chkp(63, 3, 8'h00, "R1");

    // R2 attribute commands
    cmd(C_EN_SET, 7, 4'b0101);
    chkattr(7, 4'b0001, 5'b10000, "R2");
    chkattr(7, 4'b1010, 5'b00000, "R2");
    cmd(C_EN_CLR, 7, 4'b0001);
    chkattr(7, 4'b0001, 5'b00000, "R2");
    cmd(C_A_SET, 7, 4'b1000);
    cmd(C_G_SET, 7, 4'b0010);
    chkattr(7, 4'b1110, 5'b11100, "R2");
    cmd(4'd15, 7, 4'hF);
    cmd(4'd14, 7, 4'hF);
    chkattr(7, 4'b0111, 5'b10100, "R2");
    cmd(C_A_CLR, 7, 4'hF);
    cmd(C_G_CLR, 7, 4'hF);
    chkattr(7, 4'hF, 5'b10000, "R2");
    cmd(C_E_SET, 9, 4'h0);
    cmd(C_M_SET, 9, 4'h0);
    chkattr(9, 4'h0, 5'b00011, "R2");
    cmd(C_E_CLR, 9, 4'h0);
    cmd(C_M_CLR, 9, 4'h0);
    chkattr(9, 4'h0, 5'b00000, "R2");

    // R3 level-triggered follows line
    set_line(5, 1, 1'b1);
    chk(5, 4'b0010, 1'b1, "R3");
    chk(5, 4'b0001, 1'b0, "R3");
    // R11 combinational query: switch ID within one low phase
    q_irq = IW'(5); q_mask = 4'b0010; #0.3;
    n_chk++;
    if (q_pending !== 1'b1) begin n_fail++; $display("FAIL R11 comb: actual %b expected 1", q_pending); end
    q_irq = IW'(4); #0.3;
    n_chk++;
    if (q_pending !== 1'b0) begin n_fail++; $display("FAIL R11 comb: actual %b expected 0", q_pending); end
    set_line(5, 1, 1'b0);
    chk(5, 4'b0010, 1'b0, "R3");

    // R4 edge-triggered
    cmd(C_E_SET, 40, 4'h0);
    set_line(40, 2, 1'b1);
    chk(40, 4'b0100, 1'b1, "R4");
    set_line(40, 2, 1'b0);
    chk(40, 4'b0100, 1'b1, "R4");
    cmd(C_P_CLR, 40, 4'b0100);
    chk(40, 4'b0100, 1'b0, "R4");
    set_line(40, 2, 1'b1);
    chk(40, 4'b0100, 1'b1, "R4");
    cmd(C_P_CLR, 40, 4'b0100);
    chk(40, 4'b0100, 1'b0, "R4");
    chk(40, 4'hF, 1'b0, "R4");

    // R7 edge wins over same-cycle clear
    set_line(40, 2, 1'b0);
    @(negedge clk);
    lvl_in[40*NCPU + 2] = 1'b1;
    cmd_valid = 1'b1; cmd_op = C_P_CLR; cmd_irq = IW'(40); cmd_mask = 4'b0100;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(40, 4'b0100, 1'b1, "R7");

    // R6 one-of-N clear versus per-CPU clear
    cmd(C_P_SET, 41, 4'hF);
    cmd(C_M_SET, 41, 4'h0);
    cmd(C_P_CLR, 41, 4'b0001);
    chk(41, 4'hF, 1'b0, "R6");
    cmd(C_P_SET, 42, 4'hF);
    cmd(C_P_CLR, 42, 4'b0001);
    chk(42, 4'b0001, 1'b0, "R6");
    chk(42, 4'b1110, 1'b1, "R6");
    chk(42, 4'b0010, 1'b1, "R6");

    // R5 level line keeps pending after clear
    set_line(6, 0, 1'b1);
    cmd(C_P_SET, 6, 4'b0001);
    cmd(C_P_CLR, 6, 4'b0001);
    chk(6, 4'b0001, 1'b1, "R5");
    set_line(6, 0, 1'b0);
    chk(6, 4'b0001, 1'b0, "R5");

    // R8 legacy revision drops level term
    set_line(6, 3, 1'b1);
    chk(6, 4'b1000, 1'b1, "R8");
    @(negedge clk); legacy_rev = 1'b1;
    chk(6, 4'b1000, 1'b0, "R8");
    cmd(C_P_SET, 6, 4'b1000);
    chk(6, 4'b1000, 1'b1, "R8");
    cmd(C_P_CLR, 6, 4'b1000);
    chk(6, 4'b1000, 1'b0, "R8");
    @(negedge clk); legacy_rev = 1'b0;
    chk(6, 4'b1000, 1'b1, "R8");
    set_line(6, 3, 1'b0);

    // R9 banked priorities
    cmd(C_PRIO, 3, 4'h0, 0, 8'h11);
    cmd(C_PRIO, 3, 4'h0, 2, 8'h22);
    chkp(3, 0, 8'h11, "R9");
    chkp(3, 2, 8'h22, "R9");
    chkp(3, 1, 8'h00, "R9");
    cmd(C_PRIO, 31, 4'h0, 3, 8'h33);
    chkp(31, 3, 8'h33, "R9");
    chkp(31, 0, 8'h00, "R9");

    // R10 shared priorities
    cmd(C_PRIO, 50, 4'h0, 1, 8'h77);
    chkp(50, 3, 8'h77, "R10");
    chkp(50, 0, 8'h77, "R10");
    cmd(C_PRIO, 32, 4'h0, 0, 8'h44);
    chkp(32, 2, 8'h44, "R10");
    chkp(31, 3, 8'h33, "R10");

    // Random traffic, checked every clock against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      begin
        int pick[12] = '{0, 1, 2, 3, 30, 31, 32, 33, 60, 61, 62, 63};
        cmd_valid = ($urandom % 2) == 0;
        cmd_op    = 4'($urandom % 16);
        cmd_irq   = IW'(pick[$urandom % 12]);
        cmd_mask  = NCPU'($urandom);
        cmd_cpu   = CW'($urandom);
        cmd_prio  = PW'($urandom);
        for (int b = 0; b < 4; b++)
          lvl_in[pick[$urandom % 12]*NCPU + ($urandom % NCPU)] = 1'($urandom);
        q_irq  = IW'(pick[$urandom % 12]);
        q_mask = NCPU'($urandom);
        p_irq  = IW'(pick[$urandom % 12]);
        p_cpu  = CW'($urandom);
        if (($urandom % 64) == 0) legacy_rev = ~legacy_rev;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule